// File: doc/BRIEF.md
# Tree Communication Node with In-Network Reduction

The block is one interior node of a binary tree. The tree connects a host at the root to processing elements at the leaves. The node has one parent side and two child sides (left and right). On each side, commands travel away from the host and response words travel toward it, and every channel uses a valid/ready handshake. Each command carries a 3-bit mode, an address and a 16-bit data word. The node reads one address bit, chosen by the `LEVEL` parameter, to choose a child. All traffic starts at the host.

Two modes steer a word away from the host: a write goes to one addressed child, and a broadcast goes to both children. Three modes collect a word back toward the host. A read returns the addressed child's response. A sum adds the two children's responses and wraps at 16 bits. A max returns the larger of the two responses, compared as signed values. The node forwards each upward command to the children it involves, so that the leaves can answer, and it records the operation until it has produced the result. Every command and every response passes through one register stage per tree level, so latency grows with log2 of the leaf count.

Each response word carries a flag. In sum mode the node raises the flag on signed overflow at its own level, or when either child's flag is set. This reports overflow anywhere in the subtree.

Top module: `tnode`

## Requirements
- R1: While reset is high, and on the cycle after it, no output valid (left command, right command, parent response) is asserted.
- R2: A command with mode 0 (write) goes to the left child when address bit `LEVEL` is 0 and to the right child when it is 1. It appears there one cycle after acceptance, with unchanged mode, address and data, and the other child gets nothing.
- R3: A command with mode 1 (broadcast) appears on both children one cycle after acceptance. It is accepted only when both child command registers can take it.
- R4: A command with mode 2 (read) goes to the addressed child. That child's next response word and flag appear at the parent one cycle after they are accepted. The other child's response channel is not accepted.
- R5: A command with mode 3 (sum) goes to both children. The response is the left word plus the right word modulo 2^16. Its flag is the signed overflow of that addition ORed with both child flags.
- R6: A command with mode 4 (max) goes to both children. The response is the larger of the two words as signed 16-bit values, with the left word chosen on a tie. The flag comes from the chosen word.
- R7: Only one upward operation (modes 2, 3 and 4) is outstanding at a time. A new command with mode 2, 3 or 4 is not accepted until the pending result has been loaded toward the parent.
- R8: An output valid that is not accepted stays asserted, and its data stays unchanged in the next cycle, on all three output channels.
- R9: Mode codes 5, 6 and 7 are accepted at once and discarded. No child command and no pending operation results from them.
- R10: Child response words are not accepted while no upward operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_cmd_vld | input | 1 | Command from the parent is valid |
| par_cmd_ready | output | 1 | Node accepts the parent command |
| par_cmd_mode | input | 3 | Transfer mode code |
| par_cmd_addr | input | ADDR_W | Leaf address |
| par_cmd_data | input | DATA_W | Command data word |
| par_rsp_vld | output | 1 | Response toward the parent is valid |
| par_rsp_ready | input | 1 | Parent accepts the response |
| par_rsp_data | output | DATA_W | Response word |
| par_rsp_ovf | output | 1 | Overflow flag of the response |
| lc_cmd_vld | output | 1 | Command to the left child is valid |
| lc_cmd_ready | input | 1 | Left child accepts the command |
| lc_cmd_mode | output | 3 | Mode forwarded to the left child |
| lc_cmd_addr | output | ADDR_W | Address forwarded to the left child |
| lc_cmd_data | output | DATA_W | Data forwarded to the left child |
| rc_cmd_vld | output | 1 | Command to the right child is valid |
| rc_cmd_ready | input | 1 | Right child accepts the command |
| rc_cmd_mode | output | 3 | Mode forwarded to the right child |
| rc_cmd_addr | output | ADDR_W | Address forwarded to the right child |
| rc_cmd_data | output | DATA_W | Data forwarded to the right child |
| lc_rsp_vld | input | 1 | Left child response is valid |
| lc_rsp_ready | output | 1 | Node accepts the left response |
| lc_rsp_data | input | DATA_W | Left child response word |
| lc_rsp_ovf | input | 1 | Left child overflow flag |
| rc_rsp_vld | input | 1 | Right child response is valid |
| rc_rsp_ready | output | 1 | Node accepts the right response |
| rc_rsp_data | input | DATA_W | Right child response word |
| rc_rsp_ovf | input | 1 | Right child overflow flag |

## Verification
The properties assume that the parent and both children keep to the handshake: a word, once valid, stays valid and unchanged until it is accepted. The properties also assume that the node's pending operation decides which response words belong together. The stimulus holds every command and every child response until the handshake completes, and it raises new ones only after acceptance. Response words may arrive before any command asks for them, and the bench uses this to show that they are left alone. Response data is drawn from boundary values (0x7FFF, 0x8000, 0xFFFF, 0x0001) with forced ties, so that the checks reach signed overflow and equal operands.

// File: rtl/tnode_pkg.sv
package tnode_pkg;
  localparam int MODE_W = 3;
  typedef logic [MODE_W-1:0] mode_t;

  // Mode codes; the order is part of the command format seen by every node.
  localparam mode_t OP_WRITE = 3'd0;
  localparam mode_t OP_BCAST = 3'd1;
  localparam mode_t OP_READ  = 3'd2;
  localparam mode_t OP_SUM   = 3'd3;
  localparam mode_t OP_MAX   = 3'd4;

  function automatic logic is_upward(mode_t m);
    return (m == OP_READ) || (m == OP_SUM) || (m == OP_MAX);
  endfunction
endpackage

// File: rtl/tnode_slot.sv
// One registered command stage toward a child.
module tnode_slot
  import tnode_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  mode_t             in_mode,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              can_take,
  output logic              out_vld,
  input  logic              out_rdy,
  output mode_t             out_mode,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  assign can_take = !out_vld || out_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
    end else if (load) begin
      out_vld <= 1'b1;
    end else if (out_rdy) begin
      out_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_mode <= in_mode;
      out_addr <= in_addr;
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/tnode_steer.sv
// Decodes a parent command into child loads and a pending upward operation.
module tnode_steer
  import tnode_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           cmd_vld,
  input  mode_t          cmd_mode,
  input  logic           route_bit,
  input  logic [NCH-1:0] can_take,
  input  logic           pend_vld,
  output logic           cmd_ready,
  output logic [NCH-1:0] load,
  output logic           set_pend
);
  logic [NCH-1:0] target;
  logic           upward;
  logic           fits;

  always_comb begin
    target = '0;
    case (cmd_mode)
      OP_WRITE, OP_READ:        target[route_bit] = 1'b1;
      OP_BCAST, OP_SUM, OP_MAX: target = '1;
      default:                  target = '0;
    endcase
  end

  assign upward    = is_upward(cmd_mode);
  assign fits      = ((target & ~can_take) == '0) && !(upward && pend_vld);
  assign cmd_ready = fits;
  assign load      = {NCH{cmd_vld && fits}} & target;
  assign set_pend  = cmd_vld && fits && upward;
endmodule

// File: rtl/tnode_reduce.sv
// Holds the pending upward operation, combines child words, registers the result.
module tnode_reduce
  import tnode_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   set_pend,
  input  mode_t                  set_op,
  input  logic                   set_sel,
  output logic                   pend_vld,
  output mode_t                  pend_op,
  input  logic [1:0]             ch_vld,
  output logic [1:0]             ch_rdy,
  input  logic [1:0][DATA_W-1:0] ch_data,
  input  logic [1:0]             ch_ovf,
  output logic                   up_vld,
  input  logic                   up_rdy,
  output logic [DATA_W-1:0]      up_data,
  output logic                   up_ovf
);
  localparam int MSB = DATA_W - 1;

  logic              pend_sel;
  logic              have_inputs;
  logic              out_free;
  logic              fire;
  logic [DATA_W-1:0] sum_w;
  logic              sum_ovf;
  logic              right_wins;
  logic [DATA_W-1:0] res_data;
  logic              res_ovf;

  assign have_inputs = pend_vld &&
                       ((pend_op == OP_READ) ? ch_vld[pend_sel] : (ch_vld[0] && ch_vld[1]));
  assign out_free = !up_vld || up_rdy;
  assign fire     = have_inputs && out_free;

  always_comb begin
    ch_rdy = '0;
    if (fire) begin
      if (pend_op == OP_READ) ch_rdy[pend_sel] = 1'b1;
      else                    ch_rdy = 2'b11;
    end
  end

  assign sum_w      = ch_data[0] + ch_data[1];
  assign sum_ovf    = (ch_data[0][MSB] == ch_data[1][MSB]) && (sum_w[MSB] != ch_data[0][MSB]);
  assign right_wins = $signed(ch_data[1]) > $signed(ch_data[0]);

  always_comb begin
    case (pend_op)
      OP_SUM: begin
        res_data = sum_w;
        res_ovf  = sum_ovf || ch_ovf[0] || ch_ovf[1];
      end
      OP_MAX: begin
        res_data = right_wins ? ch_data[1] : ch_data[0];
        res_ovf  = right_wins ? ch_ovf[1] : ch_ovf[0];
      end
      default: begin
        res_data = ch_data[pend_sel];
        res_ovf  = ch_ovf[pend_sel];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld <= 1'b0;
    end else if (set_pend) begin
      pend_vld <= 1'b1;
    end else if (fire) begin
      pend_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (set_pend) begin
      pend_op  <= set_op;
      pend_sel <= set_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_vld <= 1'b0;
    end else if (fire) begin
      up_vld <= 1'b1;
    end else if (up_rdy) begin
      up_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      up_data <= res_data;
      up_ovf  <= res_ovf;
    end
  end
endmodule

// File: rtl/tnode.sv
module tnode
  import tnode_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int LEVEL  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_cmd_vld,
  output logic              par_cmd_ready,
  input  logic [2:0]        par_cmd_mode,
  input  logic [ADDR_W-1:0] par_cmd_addr,
  input  logic [DATA_W-1:0] par_cmd_data,
  output logic              par_rsp_vld,
  input  logic              par_rsp_ready,
  output logic [DATA_W-1:0] par_rsp_data,
  output logic              par_rsp_ovf,
  output logic              lc_cmd_vld,
  input  logic              lc_cmd_ready,
  output logic [2:0]        lc_cmd_mode,
  output logic [ADDR_W-1:0] lc_cmd_addr,
  output logic [DATA_W-1:0] lc_cmd_data,
  output logic              rc_cmd_vld,
  input  logic              rc_cmd_ready,
  output logic [2:0]        rc_cmd_mode,
  output logic [ADDR_W-1:0] rc_cmd_addr,
  output logic [DATA_W-1:0] rc_cmd_data,
  input  logic              lc_rsp_vld,
  output logic              lc_rsp_ready,
  input  logic [DATA_W-1:0] lc_rsp_data,
  input  logic              lc_rsp_ovf,
  input  logic              rc_rsp_vld,
  output logic              rc_rsp_ready,
  input  logic [DATA_W-1:0] rc_rsp_data,
  input  logic              rc_rsp_ovf
);
  localparam int NCH = 2;

  logic [NCH-1:0]             can_take;
  logic [NCH-1:0]             load;
  logic [NCH-1:0]             ch_cmd_vld;
  logic [NCH-1:0]             ch_cmd_rdy;
  logic [NCH-1:0][2:0]        ch_cmd_mode;
  logic [NCH-1:0][ADDR_W-1:0] ch_cmd_addr;
  logic [NCH-1:0][DATA_W-1:0] ch_cmd_data;
  logic                       set_pend;
  logic                       pend_vld;
  mode_t                      pend_op;
  logic                       route_bit;
  logic [1:0]                 ch_rsp_rdy;

  assign route_bit  = par_cmd_addr[LEVEL];
  assign ch_cmd_rdy = {rc_cmd_ready, lc_cmd_ready};

  for (genvar gi = 0; gi < NCH; gi++) begin : g_child
    tnode_slot #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .load     (load[gi]),
      .in_mode  (par_cmd_mode),
      .in_addr  (par_cmd_addr),
      .in_data  (par_cmd_data),
      .can_take (can_take[gi]),
      .out_vld  (ch_cmd_vld[gi]),
      .out_rdy  (ch_cmd_rdy[gi]),
      .out_mode (ch_cmd_mode[gi]),
      .out_addr (ch_cmd_addr[gi]),
      .out_data (ch_cmd_data[gi])
    );
  end

  assign lc_cmd_vld  = ch_cmd_vld[0];
  assign lc_cmd_mode = ch_cmd_mode[0];
  assign lc_cmd_addr = ch_cmd_addr[0];
  assign lc_cmd_data = ch_cmd_data[0];
  assign rc_cmd_vld  = ch_cmd_vld[1];
  assign rc_cmd_mode = ch_cmd_mode[1];
  assign rc_cmd_addr = ch_cmd_addr[1];
  assign rc_cmd_data = ch_cmd_data[1];

  tnode_steer #(.NCH(NCH)) u_steer (
    .cmd_vld   (par_cmd_vld),
    .cmd_mode  (par_cmd_mode),
    .route_bit (route_bit),
    .can_take  (can_take),
    .pend_vld  (pend_vld),
    .cmd_ready (par_cmd_ready),
    .load      (load),
    .set_pend  (set_pend)
  );

  tnode_reduce #(.DATA_W(DATA_W)) u_reduce (
    .clk      (clk),
    .rst      (rst),
    .set_pend (set_pend),
    .set_op   (par_cmd_mode),
    .set_sel  (route_bit),
    .pend_vld (pend_vld),
    .pend_op  (pend_op),
    .ch_vld   ({rc_rsp_vld, lc_rsp_vld}),
    .ch_rdy   (ch_rsp_rdy),
    .ch_data  ({rc_rsp_data, lc_rsp_data}),
    .ch_ovf   ({rc_rsp_ovf, lc_rsp_ovf}),
    .up_vld   (par_rsp_vld),
    .up_rdy   (par_rsp_ready),
    .up_data  (par_rsp_data),
    .up_ovf   (par_rsp_ovf)
  );

  assign lc_rsp_ready = ch_rsp_rdy[0];
  assign rc_rsp_ready = ch_rsp_rdy[1];
endmodule

// File: rtl/tnode_chk.sv
module tnode_chk
  import tnode_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int LEVEL  = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              par_cmd_vld,
  input logic              par_cmd_ready,
  input logic [2:0]        par_cmd_mode,
  input logic [ADDR_W-1:0] par_cmd_addr,
  input logic [DATA_W-1:0] par_cmd_data,
  input logic              par_rsp_vld,
  input logic              par_rsp_ready,
  input logic [DATA_W-1:0] par_rsp_data,
  input logic              par_rsp_ovf,
  input logic              lc_cmd_vld,
  input logic              lc_cmd_ready,
  input logic [DATA_W-1:0] lc_cmd_data,
  input logic              rc_cmd_vld,
  input logic [DATA_W-1:0] lc_rsp_data,
  input logic              lc_rsp_vld,
  input logic              lc_rsp_ready,
  input logic [DATA_W-1:0] rc_rsp_data,
  input logic              rc_rsp_ready,
  input logic              pend_vld,
  input logic [2:0]        pend_op
);
  logic [DATA_W-1:0] sum_w;
  logic [DATA_W-1:0] max_w;
  logic              acc;

  assign sum_w = lc_rsp_data + rc_rsp_data;
  assign max_w = ($signed(rc_rsp_data) > $signed(lc_rsp_data)) ? rc_rsp_data : lc_rsp_data;
  assign acc   = par_cmd_vld && par_cmd_ready;

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !par_rsp_vld && !lc_cmd_vld && !rc_cmd_vld);

  p_write_left_r2: assert property (@(posedge clk) disable iff (rst)
    acc && par_cmd_mode == OP_WRITE && !par_cmd_addr[LEVEL]
    |=> lc_cmd_vld && lc_cmd_data == $past(par_cmd_data));

  p_bcast_both_r3: assert property (@(posedge clk) disable iff (rst)
    acc && par_cmd_mode == OP_BCAST |=> lc_cmd_vld && rc_cmd_vld);

  p_read_left_r4: assert property (@(posedge clk) disable iff (rst)
    pend_op == OP_READ && lc_rsp_vld && lc_rsp_ready
    |=> par_rsp_vld && par_rsp_data == $past(lc_rsp_data));

  p_sum_value_r5: assert property (@(posedge clk) disable iff (rst)
    pend_op == OP_SUM && lc_rsp_ready && rc_rsp_ready
    |=> par_rsp_vld && par_rsp_data == $past(sum_w));

  p_max_value_r6: assert property (@(posedge clk) disable iff (rst)
    pend_op == OP_MAX && lc_rsp_ready && rc_rsp_ready
    |=> par_rsp_vld && par_rsp_data == $past(max_w));

  p_one_pending_r7: assert property (@(posedge clk) disable iff (rst)
    pend_vld && par_cmd_vld && is_upward(par_cmd_mode) |-> !par_cmd_ready);

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    par_rsp_vld && !par_rsp_ready
    |=> par_rsp_vld && $stable(par_rsp_data) && $stable(par_rsp_ovf));

  p_lcmd_hold_r8: assert property (@(posedge clk) disable iff (rst)
    lc_cmd_vld && !lc_cmd_ready |=> lc_cmd_vld && $stable(lc_cmd_data));

  p_unknown_drop_r9: assert property (@(posedge clk) disable iff (rst)
    par_cmd_vld && par_cmd_mode > OP_MAX |-> par_cmd_ready);

  p_idle_no_take_r10: assert property (@(posedge clk) disable iff (rst)
    !pend_vld |-> !lc_rsp_ready && !rc_rsp_ready);
endmodule

bind tnode tnode_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEVEL(LEVEL)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .par_cmd_vld   (par_cmd_vld),
  .par_cmd_ready (par_cmd_ready),
  .par_cmd_mode  (par_cmd_mode),
  .par_cmd_addr  (par_cmd_addr),
  .par_cmd_data  (par_cmd_data),
  .par_rsp_vld   (par_rsp_vld),
  .par_rsp_ready (par_rsp_ready),
  .par_rsp_data  (par_rsp_data),
  .par_rsp_ovf   (par_rsp_ovf),
  .lc_cmd_vld    (lc_cmd_vld),
  .lc_cmd_ready  (lc_cmd_ready),
  .lc_cmd_data   (lc_cmd_data),
  .rc_cmd_vld    (rc_cmd_vld),
  .lc_rsp_data   (lc_rsp_data),
  .lc_rsp_vld    (lc_rsp_vld),
  .lc_rsp_ready  (lc_rsp_ready),
  .rc_rsp_data   (rc_rsp_data),
  .rc_rsp_ready  (rc_rsp_ready),
  .pend_vld      (pend_vld),
  .pend_op       (pend_op)
);

// File: tb/tnode_tb.sv
module tnode_tb;
  localparam int DW   = 16;
  localparam int AW   = 4;
  localparam int LV   = 2;
  localparam int NCYC = 6000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic          par_cmd_vld, par_cmd_ready;
  logic [2:0]    par_cmd_mode;
  logic [AW-1:0] par_cmd_addr;
  logic [DW-1:0] par_cmd_data;
  logic          par_rsp_vld, par_rsp_ready, par_rsp_ovf;
  logic [DW-1:0] par_rsp_data;
  logic          lc_cmd_vld, lc_cmd_ready, rc_cmd_vld, rc_cmd_ready;
  logic [2:0]    lc_cmd_mode, rc_cmd_mode;
  logic [AW-1:0] lc_cmd_addr, rc_cmd_addr;
  logic [DW-1:0] lc_cmd_data, rc_cmd_data;
  logic          lc_rsp_ready, rc_rsp_ready;
  logic [1:0]    rv, ro;
  logic [DW-1:0] rd [2];

  tnode #(.DATA_W(DW), .ADDR_W(AW), .LEVEL(LV)) u_dut (
    .clk(clk), .rst(rst),
    .par_cmd_vld(par_cmd_vld), .par_cmd_ready(par_cmd_ready), .par_cmd_mode(par_cmd_mode),
    .par_cmd_addr(par_cmd_addr), .par_cmd_data(par_cmd_data),
    .par_rsp_vld(par_rsp_vld), .par_rsp_ready(par_rsp_ready),
    .par_rsp_data(par_rsp_data), .par_rsp_ovf(par_rsp_ovf),
    .lc_cmd_vld(lc_cmd_vld), .lc_cmd_ready(lc_cmd_ready), .lc_cmd_mode(lc_cmd_mode),
    .lc_cmd_addr(lc_cmd_addr), .lc_cmd_data(lc_cmd_data),
    .rc_cmd_vld(rc_cmd_vld), .rc_cmd_ready(rc_cmd_ready), .rc_cmd_mode(rc_cmd_mode),
    .rc_cmd_addr(rc_cmd_addr), .rc_cmd_data(rc_cmd_data),
    .lc_rsp_vld(rv[0]), .lc_rsp_ready(lc_rsp_ready), .lc_rsp_data(rd[0]), .lc_rsp_ovf(ro[0]),
    .rc_rsp_vld(rv[1]), .rc_rsp_ready(rc_rsp_ready), .rc_rsp_data(rd[1]), .rc_rsp_ovf(ro[1])
  );

  typedef struct {logic [2:0] m; logic [AW-1:0] a; logic [DW-1:0] d;} cmd_s;
  typedef struct {logic [DW-1:0] d; logic o; int op;} rsp_s;

  cmd_s cq [2][$];
  rsp_s uq [$];
  bit   pv;
  int   pop_m;
  int   psel;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pick_word();
    case ($urandom_range(0, 5))
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'hFFFF;
      3: return 16'h0001;
      default: return DW'($urandom);
    endcase
  endfunction

  function automatic string up_tag(int op);
    if (op == 2) return "R4 read";
    if (op == 3) return "R5 sum";
    return "R6 max";
  endfunction

  initial begin
    rst = 1'b1;
    par_cmd_vld = 0; par_cmd_mode = 0; par_cmd_addr = 0; par_cmd_data = 0;
    par_rsp_ready = 0; lc_cmd_ready = 0; rc_cmd_ready = 0;
    rv = 0; ro = 0; rd[0] = 0; rd[1] = 0;
    pv = 0; pop_m = 0; psel = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset lc valid", lc_cmd_vld, 0);
    chk("R1 reset rc valid", rc_cmd_vld, 0);
    chk("R1 reset rsp valid", par_rsp_vld, 0);
    rst = 1'b0;
    begin
      bit acc_cmd = 0;
      bit [1:0] acc_rsp = 0;
      for (int cyc = 0; cyc < NCYC; cyc++) begin
        bit [1:0] tgt, take, crdy, raised;
        bit bit_sel, upm, exp_ready, want, fire;
        int m;
        rsp_s res;
        if (cyc > 0) @(negedge clk);
        if (acc_cmd) par_cmd_vld = 0;
        for (int i = 0; i < 2; i++) if (acc_rsp[i]) rv[i] = 0;
        // state comparison
        chk("R2 R3 R8 left cmd valid", lc_cmd_vld, cq[0].size() != 0);
        if (cq[0].size() != 0) begin
          chk("R2 R3 left cmd mode", lc_cmd_mode, cq[0][0].m);
          chk("R2 R3 left cmd addr", lc_cmd_addr, cq[0][0].a);
          chk("R2 R3 R8 left cmd data", lc_cmd_data, cq[0][0].d);
        end
        chk("R2 R3 R8 right cmd valid", rc_cmd_vld, cq[1].size() != 0);
        if (cq[1].size() != 0) begin
          chk("R2 R3 right cmd mode", rc_cmd_mode, cq[1][0].m);
          chk("R2 R3 right cmd addr", rc_cmd_addr, cq[1][0].a);
          chk("R2 R3 R8 right cmd data", rc_cmd_data, cq[1][0].d);
        end
        chk("R8 rsp valid", par_rsp_vld, uq.size() != 0);
        if (uq.size() != 0) begin
          chk(up_tag(uq[0].op), par_rsp_data, uq[0].d);
          chk(up_tag(uq[0].op), par_rsp_ovf, uq[0].o);
        end
        // new stimulus, held until accepted
        if (!par_cmd_vld && $urandom_range(0, 2) != 0) begin
          m = $urandom_range(0, 9);
          par_cmd_vld  = 1;
          par_cmd_mode = (m < 2) ? 3'd0 : (m == 2) ? 3'd1 : (m == 3) ? 3'd2 :
                         (m < 6) ? 3'd3 : (m < 8) ? 3'd4 : 3'($urandom_range(5, 7));
          par_cmd_addr = AW'($urandom);
          par_cmd_data = pick_word();
        end
        raised = 0;
        for (int i = 0; i < 2; i++) begin
          if (!rv[i] && $urandom_range(0, 1) != 0) begin
            rv[i] = 1; rd[i] = pick_word(); ro[i] = ($urandom_range(0, 7) == 0);
            raised[i] = 1;
          end
        end
        if (raised == 2'b11 && $urandom_range(0, 3) == 0) rd[1] = rd[0];
        lc_cmd_ready  = ($urandom_range(0, 3) != 0);
        rc_cmd_ready  = ($urandom_range(0, 3) != 0);
        par_rsp_ready = ($urandom_range(0, 2) != 0);
        #1;
        // expected handshakes
        take[0] = (cq[0].size() == 0) || lc_cmd_ready;
        take[1] = (cq[1].size() == 0) || rc_cmd_ready;
        bit_sel = par_cmd_addr[LV];
        case (par_cmd_mode)
          3'd0, 3'd2:       tgt = bit_sel ? 2'b10 : 2'b01;
          3'd1, 3'd3, 3'd4: tgt = 2'b11;
          default:          tgt = 2'b00;
        endcase
        upm = (par_cmd_mode >= 3'd2) && (par_cmd_mode <= 3'd4);
        exp_ready = ((tgt & ~take) == 0) && !(upm && pv);
        chk("R3 R7 R9 cmd ready", par_cmd_ready, exp_ready);
        want = pv && ((pop_m == 2) ? rv[psel] : (rv == 2'b11));
        fire = want && ((uq.size() == 0) || par_rsp_ready);
        crdy = 0;
        if (fire) crdy = (pop_m == 2) ? (psel ? 2'b10 : 2'b01) : 2'b11;
        chk("R4 R10 left rsp ready", lc_rsp_ready, crdy[0]);
        chk("R4 R10 right rsp ready", rc_rsp_ready, crdy[1]);
        res.op = pop_m;
        if (pop_m == 3) begin
          int sa, sb, s;
          sa = $signed(rd[0]); sb = $signed(rd[1]); s = sa + sb;
          res.d = DW'(s);
          res.o = (s > 32767) || (s < -32768) || ro[0] || ro[1];
        end else if (pop_m == 4) begin
          int sa, sb;
          sa = $signed(rd[0]); sb = $signed(rd[1]);
          res.d = (sb > sa) ? rd[1] : rd[0];
          res.o = (sb > sa) ? ro[1] : ro[0];
        end else begin
          res.d = rd[psel];
          res.o = ro[psel];
        end
        @(posedge clk);
        // model update
        if (uq.size() != 0 && par_rsp_ready) void'(uq.pop_front());
        if (fire) begin uq.push_back(res); pv = 0; end
        if (cq[0].size() != 0 && lc_cmd_ready) void'(cq[0].pop_front());
        if (cq[1].size() != 0 && rc_cmd_ready) void'(cq[1].pop_front());
        acc_cmd = par_cmd_vld && exp_ready;
        if (acc_cmd) begin
          cmd_s c;
          c.m = par_cmd_mode; c.a = par_cmd_addr; c.d = par_cmd_data;
          for (int i = 0; i < 2; i++) if (tgt[i]) cq[i].push_back(c);
          if (upm) begin pv = 1; pop_m = int'(par_cmd_mode); psel = int'(bit_sel); end
        end
        acc_rsp = rv & crdy;
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (NCYC * 3) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule